// File: doc/BRIEF.md
# Dual-Mode Compare Timer With Toggle

This block is a counter that advances once per enabled clock, driven by a single tick-enable input. A mode input picks one of two counting shapes. In Up mode the counter climbs from zero to a programmable peak and then wraps to zero. In Up/Down mode it climbs to the peak and then descends to zero. A toggle output inverts each time the count arrives at the peak. A one-clock period flag marks each return to zero, so a period can be measured or chained without reading the count.

The tick accounting is exact. An Up-mode period lasts peak+1 ticks. An Up/Down period lasts 2×peak ticks, because the peak and the zero are each visited once per period. So an Up/Down timer with peak N runs at the same rate as an Up timer with peak 2N−1.

A synchronous clear puts the counter, the count direction and the toggle output into a known state. Several instances that share a tick source and are cleared on the same clock therefore run in lock-step. A peak value written while the counter runs is held in a staging register and is applied only at the next return to zero.

Top module: `tick_cmp_timer`

## Requirements
- R1: When `tick_en` is low and `clr` is low, `count` and `tog_out` keep their values and `period_evt` is low on the following cycle.
- R2: With `mode_sel`=0 (Up), the count after k ticks from a clear is k mod (P+1), where P is the active peak. One period is therefore P+1 ticks.
- R3: With `mode_sel`=1 (Up/Down) and P>0, the count after k ticks from a clear is r when r≤P and 2P−r otherwise, where r = k mod 2P. One period is 2P ticks.
- R4: `period_evt` is high for exactly the one clock that follows an enabled tick on which the count becomes 0, and the count is 0 whenever it is high.
- R5: `tog_out` inverts on the same enabled edge on which the count becomes equal to the active peak.
- R6: With an active peak of 0, the count stays at 0, while `tog_out` inverts and `period_evt` pulses on every enabled tick, in either mode.
- R7: A high `clr` takes priority over `tick_en`. On the next edge it sets the count to 0, the direction to up, `tog_out` to 0 and `period_evt` to 0, and it loads the active peak from the staged value, or from `peak_wdata` when `peak_we` is high in the same cycle.
- R8: A value written with `peak_we` becomes the active peak only on the next tick on which the count becomes 0. The count never exceeds the active peak.
- R9: After reset, `count`=0, `tog_out`=0, `period_evt`=0, and both the staged and active peak are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | Count enable, one tick per high cycle |
| mode_sel | input | 1 | 0 = Up, 1 = Up/Down |
| clr | input | 1 | Synchronous clear of count, direction and output |
| peak_wdata | input | W | New peak value |
| peak_we | input | 1 | Write strobe for the staged peak |
| count | output | W | Current counter value |
| period_evt | output | 1 | One-clock pulse when the count returns to 0 |
| tog_out | output | 1 | Output that inverts at each peak |

## Verification
The hardest case to reach is a peak written in the middle of a period, most of all in Up/Down mode while the counter is still rising toward the old peak. An early load there would send the count past the new peak or reverse it too soon. The bench clears the counter with a large peak, ticks partway up, writes a smaller peak, and then checks that the old turnaround still happens and that the new period starts only after the count returns to zero. A separate sweep covers every small peak in both modes, with idle cycles mixed in. It compares each count, toggle and flag against closed-form formulas in the tick index.

// File: rtl/tct_pkg.sv
package tct_pkg;
  typedef enum logic {
    MODE_UP     = 1'b0,
    MODE_UPDOWN = 1'b1
  } tct_mode_e;
endpackage

// File: rtl/tct_peak_reg.sv
module tct_peak_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         we,
  input  logic [W-1:0] wdata,
  input  logic         load,
  output logic [W-1:0] act_q
);
  logic [W-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      act_q   <= '0;
    end else begin
      if (we) stage_q <= wdata;
      if (clr) act_q <= we ? wdata : stage_q;
      else if (load) act_q <= stage_q;
    end
  end
endmodule

// File: rtl/tct_step.sv
module tct_step
  import tct_pkg::*;
#(
  parameter int W = 8
) (
  input  tct_mode_e    mode,
  input  logic         tick,
  input  logic [W-1:0] cur,
  input  logic         cur_up,
  input  logic [W-1:0] peak,
  output logic [W-1:0] nxt,
  output logic         nxt_up,
  output logic         hit_peak,
  output logic         hit_zero
);
  function automatic logic [W-1:0] up_next(input logic [W-1:0] c, input logic [W-1:0] p);
    return (c >= p) ? '0 : W'(c + 1'b1);
  endfunction

  // returns {direction_up, next_count}
  function automatic logic [W:0] updn_next(input logic [W-1:0] c, input logic [W-1:0] p,
                                           input logic d);
    if (p == '0) return {1'b1, {W{1'b0}}};
    if (d) begin
      if (c >= p) begin
        if (c <= W'(1)) return {1'b1, {W{1'b0}}};
        return {1'b0, W'(c - 1'b1)};
      end
      return {1'b1, W'(c + 1'b1)};
    end
    if (c <= W'(1)) return {1'b1, {W{1'b0}}};
    return {1'b0, W'(c - 1'b1)};
  endfunction

  logic [W:0] ud;
  assign ud = updn_next(cur, peak, cur_up);

  always_comb begin
    if (mode == MODE_UP) begin
      nxt    = up_next(cur, peak);
      nxt_up = 1'b1;
    end else begin
      nxt    = ud[W-1:0];
      nxt_up = ud[W];
    end
  end

  assign hit_peak = tick && (nxt == peak);
  assign hit_zero = tick && (nxt == '0);
endmodule

// File: rtl/tct_out.sv
module tct_out (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic hit_peak,
  input  logic hit_zero,
  output logic tog_q,
  output logic evt_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_q <= 1'b0;
      evt_q <= 1'b0;
    end else if (clr) begin
      tog_q <= 1'b0;
      evt_q <= 1'b0;
    end else begin
      evt_q <= hit_zero;
      if (hit_peak) tog_q <= ~tog_q;
    end
  end
endmodule

// File: rtl/tick_cmp_timer.sv
module tick_cmp_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_en,
  input  logic         mode_sel,
  input  logic         clr,
  input  logic [W-1:0] peak_wdata,
  input  logic         peak_we,
  output logic [W-1:0] count,
  output logic         period_evt,
  output logic         tog_out
);
  import tct_pkg::*;

  tct_mode_e    mode;
  logic         dir_up;
  logic [W-1:0] act_peak;
  logic [W-1:0] nxt_count;
  logic         nxt_dir_up;
  logic         hit_peak;
  logic         hit_zero;

  assign mode = tct_mode_e'(mode_sel);

  tct_peak_reg #(.W(W)) u_peak (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .we    (peak_we),
    .wdata (peak_wdata),
    .load  (hit_zero),
    .act_q (act_peak)
  );

  tct_step #(.W(W)) u_step (
    .mode     (mode),
    .tick     (tick_en),
    .cur      (count),
    .cur_up   (dir_up),
    .peak     (act_peak),
    .nxt      (nxt_count),
    .nxt_up   (nxt_dir_up),
    .hit_peak (hit_peak),
    .hit_zero (hit_zero)
  );

  tct_out u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .hit_peak (hit_peak),
    .hit_zero (hit_zero),
    .tog_q    (tog_out),
    .evt_q    (period_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count  <= '0;
      dir_up <= 1'b1;
    end else if (clr) begin
      count  <= '0;
      dir_up <= 1'b1;
    end else if (tick_en) begin
      count  <= nxt_count;
      dir_up <= nxt_dir_up;
    end
  end
endmodule

// File: rtl/tct_checker.sv
module tct_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick_en,
  input logic         clr,
  input logic         mode_sel,
  input logic [W-1:0] count,
  input logic         period_evt,
  input logic         tog_out,
  input logic [W-1:0] act_peak,
  input logic [W-1:0] nxt_count
);
  a_r1_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !clr) |=> ($stable(count) && $stable(tog_out) && !period_evt));

  a_r2_up_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !clr && !mode_sel && count == act_peak) |=> (count == '0));

  a_r3_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !clr && mode_sel && count == act_peak && act_peak != '0)
      |=> (count == W'($past(count) - 1'b1)));

  a_r4_evt_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    period_evt |-> (count == '0));

  a_r5_toggle_at_peak: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !clr && nxt_count == act_peak) |=> (tog_out != $past(tog_out)));

  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0 && !tog_out && !period_evt));

  a_r8_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    count <= act_peak);
endmodule

bind tick_cmp_timer tct_checker #(.W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick_en    (tick_en),
  .clr        (clr),
  .mode_sel   (mode_sel),
  .count      (count),
  .period_evt (period_evt),
  .tog_out    (tog_out),
  .act_peak   (act_peak),
  .nxt_count  (nxt_count)
);

// File: tb/tb_tick_cmp_timer.sv
module tb_tick_cmp_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic       mode_sel = 1'b0;
  logic       clr = 1'b0;
  logic [7:0] peak_wdata = '0;
  logic       peak_we = 1'b0;
  logic [7:0] count;
  logic       period_evt;
  logic       tog_out;
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  tick_cmp_timer #(.W(8)) dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .mode_sel(mode_sel), .clr(clr),
    .peak_wdata(peak_wdata), .peak_we(peak_we), .count(count),
    .period_evt(period_evt), .tog_out(tog_out)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic t, input logic c, input logic we, input int wd);
    @(negedge clk);
    tick_en = t; clr = c; peak_we = we; peak_wdata = 8'(wd);
    @(posedge clk);
    #1;
  endtask

  function automatic int e_cnt(input int m, input int p, input int k);
    int r;
    if (p == 0) return 0;
    if (m == 0) return k % (p + 1);
    r = k % (2 * p);
    return (r <= p) ? r : 2 * p - r;
  endfunction

  function automatic int e_togs(input int m, input int p, input int k);
    if (p == 0) return k;
    if (m == 0) return (k + 1) / (p + 1);
    return (k >= p) ? (k - p) / (2 * p) + 1 : 0;
  endfunction

  function automatic int e_evt(input int m, input int p, input int k);
    if (p == 0) return 1;
    if (m == 0) return (k % (p + 1) == 0) ? 1 : 0;
    return (k % (2 * p) == 0) ? 1 : 0;
  endfunction

  initial begin
    #1_000_000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    // R9 reset state
    chk("R9 count", count, 0);
    chk("R9 tog", tog_out, 0);
    chk("R9 evt", period_evt, 0);
    // R9 active peak 0 after reset: holds at 0, toggles (R6)
    cyc(1, 0, 0, 0);
    chk("R9 count peak0", count, 0);
    chk("R9 tog peak0", tog_out, 1);
    chk("R6 evt peak0", period_evt, 1);

    // Sweep both modes and small peaks with idle cycles mixed in
    for (int m = 0; m < 2; m++) begin
      for (int p = 0; p < 7; p++) begin
        int k, per;
        mode_sel = m[0];
        cyc(0, 0, 1, p);
        cyc(1, 1, 0, 0);
        chk("R7 clr count", count, 0);
        chk("R7 clr tog", tog_out, 0);
        chk("R7 clr evt", period_evt, 0);
        k = 0;
        per = (p == 0) ? 1 : ((m == 0) ? p + 1 : 2 * p);
        for (int i = 0; i < 4 * per + 6; i++) begin
          logic t;
          t = (i % 4) != 3;
          cyc(t, 0, 0, 0);
          if (t) k++;
          if (!t)
            chk("R1 idle evt", period_evt, 0);
          else
            chk((p == 0) ? "R6 evt" : "R4 evt", period_evt, e_evt(m, p, k));
          chk((p == 0) ? "R6 count" : ((m == 0) ? "R2 count" : "R3 count"),
              count, e_cnt(m, p, k));
          chk((p == 0) ? "R6 tog" : "R5 tog", tog_out, e_togs(m, p, k) % 2);
        end
      end
    end

    // R7: clear with write and tick in the same cycle loads the new peak
    mode_sel = 1'b0;
    cyc(1, 1, 1, 2);
    chk("R7 clr+we count", count, 0);
    cyc(1, 0, 0, 0); chk("R7 loaded peak", count, 1);
    cyc(1, 0, 0, 0); chk("R7 loaded peak", count, 2);
    cyc(1, 0, 0, 0); chk("R7 loaded peak", count, 0);

    // R8: mid-period write, Up mode
    begin
      int exp_up[6] = '{3, 4, 0, 1, 2, 0};
      mode_sel = 1'b0;
      cyc(0, 0, 1, 4);
      cyc(0, 1, 0, 0);
      cyc(1, 0, 0, 0);
      cyc(1, 0, 0, 0);
      cyc(0, 0, 1, 2);
      chk("R8 R1 hold on write", count, 2);
      foreach (exp_up[i]) begin
        cyc(1, 0, 0, 0);
        chk("R8 up count", count, exp_up[i]);
        chk("R8 up evt", period_evt, (exp_up[i] == 0) ? 1 : 0);
      end
    end

    // R8: mid-period write, Up/Down mode while rising
    begin
      int exp_ud[8] = '{3, 2, 1, 0, 1, 0, 1, 0};
      mode_sel = 1'b1;
      cyc(0, 0, 1, 3);
      cyc(0, 1, 0, 0);
      cyc(1, 0, 0, 0);
      cyc(1, 0, 0, 0);
      cyc(0, 0, 1, 1);
      foreach (exp_ud[i]) begin
        cyc(1, 0, 0, 0);
        chk("R8 updown count", count, exp_ud[i]);
        chk("R8 updown evt", period_evt, (exp_ud[i] == 0) ? 1 : 0);
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule